// File: doc/BRIEF.md
# Timer and External Interrupt Control Register

This block is the 8-bit control and status register that sits between a small 8-bit processor core, its two counters and its interrupt logic. It holds the run enables for two timers, a sticky overflow flag for each timer, and one flag for each of two external interrupt pins. Each external interrupt has its own trigger type bit, which selects edge or level detection.

The processor writes the register as a whole byte or one bit at a time, and reads it back as a byte. The timers report overflows as one-cycle pulses. The interrupt controller returns one-cycle acknowledge strobes when it vectors to a timer or external interrupt. Raw external pins enter through a synchronizer. A separate configuration input chooses, for each pin, whether it is active high or active low.

Top module: `tic_top`

## Requirements
- R1: While reset is asserted, and right after it is released, the register reads 0x00 and all run and flag outputs are 0.
- R2: The read byte is laid out, from bit 7 to bit 0, as: timer 1 flag, timer 1 run, timer 0 flag, timer 0 run, ext 1 flag, ext 1 type, ext 0 flag, ext 0 type.
- R3: A byte write (wr_en) loads all eight bits. A bit write (bit_wr_en) loads only bit bit_sel with bit_val. If both strobes are high, the byte write wins. The new value is visible after the next rising clock edge.
- R4: tmr_run[i] equals the stored run bit of timer i. It changes only when that bit is written.
- R5: A tmr_ovf[i] pulse sets timer flag i on the next edge, and the flag stays set until it is cleared.
- R6: A tmr_ack[i] strobe clears timer flag i on the next edge.
- R7: If a hardware set event (timer overflow, or an active edge in edge mode) falls in the same cycle as an acknowledge or a software write of 0 to the same flag, the flag ends up 1.
- R8: With type bit = 1 (edge mode), ext flag i is set by an edge of the synchronized pin toward its active level. The active level is high when ext_act_high[i] = 1 and low when it is 0. An edge in the other direction does not set the flag.
- R9: In edge mode, an ext_ack[i] strobe clears ext flag i on the next edge.
- R10: With type bit = 0 (level mode), ext flag i is 1 exactly while the synchronized pin is at its active level.
- R11: In level mode, ext_ack[i] and software writes to ext flag i have no effect on it.
- R12: With SYNC_STAGES = 2, a change on ext_pin reaches ext_flag on the third rising clock edge after the change is applied.
- R13: A software write of 1 to a timer flag, or to an ext flag in edge mode, sets that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Whole-byte write strobe |
| wr_data | input | 8 | Byte write data |
| bit_wr_en | input | 1 | Single-bit write strobe |
| bit_sel | input | 3 | Index of the bit to write |
| bit_val | input | 1 | Value for the single-bit write |
| rd_data | output | 8 | Current register contents |
| tmr_ovf | input | 2 | Timer overflow pulses, bit i for timer i |
| tmr_ack | input | 2 | Timer interrupt vector acknowledge |
| tmr_run | output | 2 | Timer run enables |
| tmr_flag | output | 2 | Timer overflow flags |
| ext_pin | input | 2 | Raw asynchronous external interrupt pins |
| ext_act_high | input | 2 | Per-pin polarity: 1 active high, 0 active low |
| ext_ack | input | 2 | External interrupt vector acknowledge |
| ext_flag | output | 2 | External interrupt flags |

## Verification
The bench drives a timer overflow, an acknowledge and a software write of 0 into the same cycle, and it also lines up an acknowledge with the cycle where a pin edge is detected. A design that lets the clear win there loses the interrupt. Both polarities are tested with edges in each direction, so a detector that reacts to any change, or ignores the polarity input, sets the flag when it should not. In level mode the bench acknowledges the flag and writes 0 to it while the pin is still active; a design that latches the flag there would show 0. The bench also checks the flag one edge before and on the edge where it is due, which catches a synchronizer with one stage too many or too few.

// File: rtl/tic_pkg.sv
package tic_pkg;
    localparam int REG_W = 8;
    localparam int SEL_W = $clog2(REG_W);
    localparam int N_CH  = 2;

    typedef struct packed {
        logic [N_CH-1:0] tf;
        logic [N_CH-1:0] tr;
        logic [N_CH-1:0] ie;
        logic [N_CH-1:0] it;
    } ctl_t;

    function automatic int it_bit(input int i); return 2 * i;     endfunction
    function automatic int ie_bit(input int i); return 2 * i + 1; endfunction
    function automatic int tr_bit(input int i); return 2 * i + 4; endfunction
    function automatic int tf_bit(input int i); return 2 * i + 5; endfunction

    // Sticky flag: a hardware set wins, then a software write, then a clear.
    function automatic logic flag_next(input logic hw_set, input logic sw_wr,
                                       input logic sw_val, input logic clr,
                                       input logic cur);
        if (hw_set)     return 1'b1;
        else if (sw_wr) return sw_val;
        else if (clr)   return 1'b0;
        else            return cur;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctl(input ctl_t s);
        logic [REG_W-1:0] r;
        r = '0;
        for (int i = 0; i < N_CH; i++) begin
            r[it_bit(i)] = s.it[i];
            r[ie_bit(i)] = s.ie[i];
            r[tr_bit(i)] = s.tr[i];
            r[tf_bit(i)] = s.tf[i];
        end
        return r;
    endfunction
endpackage

// File: rtl/tic_wr_decode.sv
module tic_wr_decode #(
    parameter  int REG_W = 8,
    localparam int SEL_W = $clog2(REG_W)
) (
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             bit_wr_en,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic             bit_val,
    output logic [REG_W-1:0] wmask,
    output logic [REG_W-1:0] wval
);
    always_comb begin
        wmask = '0;
        wval  = '0;
        if (wr_en) begin
            wmask = '1;
            wval  = wr_data;
        end else if (bit_wr_en) begin
            wmask[bit_sel] = 1'b1;
            wval[bit_sel]  = bit_val;
        end
    end
endmodule

// File: rtl/tic_pin_sync.sv
module tic_pin_sync #(
    parameter  int STAGES = 2,
    localparam int CW     = STAGES + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic act_high,
    output logic lvl,
    output logic evt
);
    logic [CW-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CW-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    // chain_q[STAGES-1] is the synchronized pin, chain_q[STAGES] its prior value
    assign lvl = (chain_q[STAGES-1] == act_high);
    assign evt = lvl && (chain_q[STAGES] != act_high);
endmodule

// File: rtl/tic_top.sv
module tic_top
    import tic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             bit_wr_en,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic             bit_val,
    output logic [REG_W-1:0] rd_data,
    input  logic [N_CH-1:0]  tmr_ovf,
    input  logic [N_CH-1:0]  tmr_ack,
    output logic [N_CH-1:0]  tmr_run,
    output logic [N_CH-1:0]  tmr_flag,
    input  logic [N_CH-1:0]  ext_pin,
    input  logic [N_CH-1:0]  ext_act_high,
    input  logic [N_CH-1:0]  ext_ack,
    output logic [N_CH-1:0]  ext_flag
);
    ctl_t             st_d, st_q;
    logic [REG_W-1:0] wmask, wval;
    logic [N_CH-1:0]  lvl, evt;

    tic_wr_decode #(.REG_W(REG_W)) u_dec (
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .bit_wr_en(bit_wr_en),
        .bit_sel  (bit_sel),
        .bit_val  (bit_val),
        .wmask    (wmask),
        .wval     (wval)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_pin
        tic_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (ext_pin[g]),
            .act_high(ext_act_high[g]),
            .lvl     (lvl[g]),
            .evt     (evt[g])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_CH; i++) begin
            if (wmask[tr_bit(i)]) st_d.tr[i] = wval[tr_bit(i)];
            if (wmask[it_bit(i)]) st_d.it[i] = wval[it_bit(i)];
            st_d.tf[i] = flag_next(tmr_ovf[i], wmask[tf_bit(i)], wval[tf_bit(i)],
                                   tmr_ack[i], st_q.tf[i]);
            if (st_q.it[i])
                st_d.ie[i] = flag_next(evt[i], wmask[ie_bit(i)], wval[ie_bit(i)],
                                       ext_ack[i], st_q.ie[i]);
            else
                st_d.ie[i] = lvl[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data  = pack_ctl(st_q);
    assign tmr_run  = st_q.tr;
    assign tmr_flag = st_q.tf;
    assign ext_flag = st_q.ie;
endmodule

// File: rtl/tic_chk.sv
module tic_chk
    import tic_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             bit_wr_en,
    input logic [SEL_W-1:0] bit_sel,
    input logic [REG_W-1:0] rd_data,
    input logic [N_CH-1:0]  tmr_ovf,
    input logic [N_CH-1:0]  tmr_ack,
    input logic [N_CH-1:0]  tmr_run,
    input logic [N_CH-1:0]  tmr_flag,
    input logic [N_CH-1:0]  ext_ack,
    input logic [N_CH-1:0]  ext_flag,
    input logic [N_CH-1:0]  ext_evt,
    input logic [N_CH-1:0]  ext_lvl
);
    function automatic logic touch(input int b);
        return wr_en || (bit_wr_en && (int'(bit_sel) == b));
    endfunction

    p_run_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !bit_wr_en) |=> $stable(tmr_run));

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        p_ovf_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_ovf[g] |=> tmr_flag[g]);

        p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_ack[g] && !tmr_ovf[g] && !touch(tf_bit(g))) |=> !tmr_flag[g]);

        p_edge_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[it_bit(g)] && ext_evt[g]) |=> ext_flag[g]);

        p_edge_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[it_bit(g)] && ext_ack[g] && !ext_evt[g] && !touch(ie_bit(g)))
            |=> !ext_flag[g]);

        p_level_tracks_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_data[it_bit(g)] |=> (ext_flag[g] == $past(ext_lvl[g])));
    end
endmodule

bind tic_top tic_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .bit_wr_en(bit_wr_en),
    .bit_sel  (bit_sel),
    .rd_data  (rd_data),
    .tmr_ovf  (tmr_ovf),
    .tmr_ack  (tmr_ack),
    .tmr_run  (tmr_run),
    .tmr_flag (tmr_flag),
    .ext_ack  (ext_ack),
    .ext_flag (ext_flag),
    .ext_evt  (evt),
    .ext_lvl  (lvl)
);

// File: tb/sim_tic_top.sv
module sim_tic_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, bit_wr_en, bit_val;
    logic [7:0] wr_data;
    logic [2:0] bit_sel;
    logic [7:0] rd_data;
    logic [1:0] tmr_ovf, tmr_ack, tmr_run, tmr_flag;
    logic [1:0] ext_pin, ext_act_high, ext_ack, ext_flag;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tic_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .bit_wr_en(bit_wr_en), .bit_sel(bit_sel), .bit_val(bit_val),
        .rd_data(rd_data), .tmr_ovf(tmr_ovf), .tmr_ack(tmr_ack),
        .tmr_run(tmr_run), .tmr_flag(tmr_flag), .ext_pin(ext_pin),
        .ext_act_high(ext_act_high), .ext_ack(ext_ack), .ext_flag(ext_flag)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic byte_wr(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v; step(1); wr_en = 1'b0;
    endtask

    task automatic bit_wr(input logic [2:0] s, input logic v);
        bit_wr_en = 1'b1; bit_sel = s; bit_val = v; step(1); bit_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wr_en = 0; bit_wr_en = 0; bit_sel = 0; bit_val = 0; wr_data = 0;
        tmr_ovf = 0; tmr_ack = 0; ext_pin = 0; ext_act_high = 2'b11; ext_ack = 0;
        step(3);
        chk("R1 in reset", rd_data, 8'h00);
        rst_n = 1'b1;
        step(1);
        chk("R1 after reset", rd_data, 8'h00);
        chk("R1 outputs", {tmr_run, tmr_flag, ext_flag}, 8'h00);
    endtask

    task automatic t_layout();
        byte_wr(8'h05);
        chk("R2 type bits", rd_data, 8'h05);
        byte_wr(8'hFF);
        chk("R2 R3 all ones", rd_data, 8'hFF);
        chk("R2 R4 run", {6'd0, tmr_run}, 8'h03);
        chk("R2 flags", {4'd0, tmr_flag, ext_flag}, 8'h0F);
        byte_wr(8'h05);
        chk("R3 byte clears", rd_data, 8'h05);
    endtask

    task automatic t_bitwr();
        bit_wr(3'd4, 1'b1);
        chk("R3 bit4 set", rd_data, 8'h15);
        chk("R4 run0", {6'd0, tmr_run}, 8'h01);
        bit_wr(3'd6, 1'b1);
        chk("R4 run both", {6'd0, tmr_run}, 8'h03);
        bit_wr(3'd4, 1'b0);
        chk("R3 bit4 clear", rd_data, 8'h45);
        bit_wr(3'd6, 1'b0);
        step(3);
        chk("R4 run held off", {6'd0, tmr_run}, 8'h00);
        // both strobes: byte write wins
        wr_en = 1'b1; wr_data = 8'h05; bit_wr_en = 1'b1; bit_sel = 3'd4; bit_val = 1'b1;
        step(1); wr_en = 0; bit_wr_en = 0;
        chk("R3 byte beats bit", rd_data, 8'h05);
    endtask

    task automatic t_timer();
        tmr_ovf = 2'b01; step(1); tmr_ovf = 0;
        chk("R5 ovf0 sets", {6'd0, tmr_flag}, 8'h01);
        step(3);
        chk("R5 flag holds", {6'd0, tmr_flag}, 8'h01);
        tmr_ack = 2'b01; step(1); tmr_ack = 0;
        chk("R6 ack clears", {6'd0, tmr_flag}, 8'h00);
        tmr_ovf = 2'b10; step(1); tmr_ovf = 0;
        chk("R5 ovf1 sets", rd_data, 8'h85);
        bit_wr(3'd7, 1'b0);
        chk("R3 sw clear tf1", {6'd0, tmr_flag}, 8'h00);
    endtask

    task automatic t_set_wins();
        tmr_ovf = 2'b10; tmr_ack = 2'b10;
        bit_wr_en = 1'b1; bit_sel = 3'd7; bit_val = 1'b0;
        step(1);
        tmr_ovf = 0; tmr_ack = 0; bit_wr_en = 0;
        chk("R7 ovf beats ack and write", {6'd0, tmr_flag}, 8'h02);
        tmr_ack = 2'b10; step(1); tmr_ack = 0;
        chk("R6 ack tf1", {6'd0, tmr_flag}, 8'h00);
    endtask

    task automatic t_sw_set();
        bit_wr(3'd5, 1'b1);
        chk("R13 sw set tf0", {6'd0, tmr_flag}, 8'h01);
        bit_wr(3'd1, 1'b1);
        chk("R13 sw set ie0 edge mode", {6'd0, ext_flag}, 8'h01);
        byte_wr(8'h05);
        chk("R13 cleanup", rd_data, 8'h05);
    endtask

    task automatic t_edge();
        ext_pin[0] = 1'b1;
        step(2);
        chk("R12 not yet", {7'd0, ext_flag[0]}, 8'h00);
        step(1);
        chk("R8 R12 rising sets", {7'd0, ext_flag[0]}, 8'h01);
        bit_wr(3'd1, 1'b0);
        chk("R3 clear ie0", {7'd0, ext_flag[0]}, 8'h00);
        ext_pin[0] = 1'b0; step(4);
        chk("R8 falling ignored high pol", {7'd0, ext_flag[0]}, 8'h00);
        ext_act_high[0] = 1'b0; step(2);
        chk("R8 polarity swap no event", {7'd0, ext_flag[0]}, 8'h00);
        ext_pin[0] = 1'b1; step(4);
        chk("R8 rising ignored low pol", {7'd0, ext_flag[0]}, 8'h00);
        ext_pin[0] = 1'b0; step(3);
        chk("R8 falling sets low pol", {7'd0, ext_flag[0]}, 8'h01);
        ext_ack = 2'b01; step(1); ext_ack = 0;
        chk("R9 ack clears edge flag", {7'd0, ext_flag[0]}, 8'h00);
        ext_act_high[0] = 1'b1; step(2);
    endtask

    task automatic t_edge_race();
        ext_pin[1] = 1'b1;
        step(2);
        ext_ack = 2'b10; step(1); ext_ack = 0;
        chk("R7 edge beats ack", {7'd0, ext_flag[1]}, 8'h01);
        ext_pin[1] = 1'b0; step(4);
        ext_ack = 2'b10; step(1); ext_ack = 0;
        chk("R9 ack clears ie1", {7'd0, ext_flag[1]}, 8'h00);
    endtask

    task automatic t_level();
        byte_wr(8'h00);
        chk("R10 level idle", {6'd0, ext_flag}, 8'h00);
        ext_pin[0] = 1'b1; step(2);
        chk("R12 level not yet", {7'd0, ext_flag[0]}, 8'h00);
        step(1);
        chk("R10 R12 level active", {7'd0, ext_flag[0]}, 8'h01);
        ext_ack = 2'b01; step(1); ext_ack = 0;
        chk("R11 ack ignored", {7'd0, ext_flag[0]}, 8'h01);
        bit_wr(3'd1, 1'b0);
        chk("R11 write ignored", {7'd0, ext_flag[0]}, 8'h01);
        ext_pin[0] = 1'b0; step(3);
        chk("R10 level released", {7'd0, ext_flag[0]}, 8'h00);
        ext_act_high[1] = 1'b0; step(1);
        chk("R10 low pol active", {7'd0, ext_flag[1]}, 8'h01);
        bit_wr(3'd3, 1'b0);
        chk("R11 write ie1 ignored", {7'd0, ext_flag[1]}, 8'h01);
        ext_pin[1] = 1'b1; step(3);
        chk("R10 low pol inactive", {7'd0, ext_flag[1]}, 8'h00);
        ext_act_high = 2'b11;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_layout();
        t_bitwr();
        t_timer();
        t_set_wins();
        t_sw_set();
        t_edge();
        t_edge_race();
        t_level();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule